// File: doc/BRIEF.md
# Buffered Configuration-Port Transfer Engine

This peripheral sits on a 32-bit register bus and holds a staging buffer of
32-bit words. Software fills the buffer (or drains it) one word at a time
through the lower half of the address map. It then sets a byte count and a
first word index, and writes a mode register. That write launches a block move
between the buffer and a 32-bit configuration port. In configure mode, words
travel from the buffer out to the port. In readback mode, words from the port
land in the buffer.

The outbound stream (`cfg_*`) is valid/ready. The engine raises `cfg_valid`
with a word and keeps that word steady until `cfg_ready` is seen high at a
rising edge. At most one word moves per cycle. The inbound stream (`rb_*`)
is valid/ready as well. The engine raises `rb_ready` for the whole readback
run, and the port may hold `rb_valid` low for as many cycles as it needs. A
status word gives a completion flag, four constant-one filler bits and the
port's four condition flags. Any write to the status word abandons the run in
progress.

The bus has no wait states. A write is taken on the edge where `bus_wr` is
high. A read issued with `bus_rd` returns its data on `bus_rdata` one cycle
later. Bit 31 of every bus word is its most significant bit, on the bus and in
the buffer alike.

Top module: `cfgport_xfer`

## Requirements
- R1: After reset the done flag is 1, the size and first-index registers read 0, and neither `cfg_valid` nor `rb_ready` is high.
- R2: Buffer word N is written and read at byte address 4×N (N < 512), and read data appears on `bus_rdata` one cycle after `bus_rd`.
- R3: The size register (byte address 0x800, 12 bits) and the first-index register (0x804, 9 bits) read back what was written, and the mode register (0x808) reads as 0.
- R4: A write to the mode register while done is 1 and size ≥ 4 starts a run, with bit 0 = 0 selecting configure and bit 0 = 1 selecting readback, and done reads 0 from the next cycle.
- R5: A configure run sends floor(size/4) words from successive buffer words, starting at the first index, and holds `cfg_data` steady while `cfg_valid` is high and `cfg_ready` is low.
- R6: A readback run stores each word taken while `rb_valid` and `rb_ready` are both high into successive buffer words, starting at the first index, and leaves the words beyond the run unchanged.
- R7: Done becomes 1 in the cycle after the last word is moved, and while done is 1 the engine holds `cfg_valid` and `rb_ready` low.
- R8: A start with size below 4 moves no word and leaves done at 1.
- R9: The buffer word index advances by one per word moved and wraps from 511 to 0.
- R10: A write of any value to the status register (0x80C) ends the run at once: done reads 1 and the port strobes go low from the next cycle.
- R11: The status word at 0x80C reads bit 0 = done, bits 1 to 4 = 1, bit 5 = `port_abort_n`, bit 6 = `port_rd_busy`, bit 7 = `port_aligned`, bit 8 = `port_cfg_err`, and all other bits 0.
- R12: A write to the mode register while done is 0 is ignored, and the current run finishes in its own mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | 12 | Byte address; bit 11 selects the register space |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data, valid one cycle after `bus_rd` |
| cfg_valid | output | 1 | Outbound word valid (configure) |
| cfg_ready | input | 1 | Port accepts the outbound word |
| cfg_data | output | 32 | Outbound word |
| rb_valid | input | 1 | Inbound word valid (readback) |
| rb_ready | output | 1 | Engine accepts the inbound word |
| rb_data | input | 32 | Inbound word |
| port_abort_n | input | 1 | Port abort flag, active low |
| port_rd_busy | input | 1 | Port read-in-progress flag |
| port_aligned | input | 1 | Port data-aligned flag |
| port_cfg_err | input | 1 | Port configuration-error flag |

## Verification
Configure runs are driven against a port that drops ready on every third cycle.
This shows whether the engine holds its word through back-pressure and still
sends every word exactly once. Readback runs use an inbound stream with gaps.
This shows whether a word is stored only on a real handshake, and the untouched
word past the run end shows whether the engine stops at the right count. A run
that starts at index 510 shows whether the index wraps. A byte count that is
not a multiple of four shows whether the size is rounded down to whole words.
A zero size, an abort written while the port is stalled, and a mode write
issued during a stalled run show whether done and the port strobes stay in the
right state when no word is moved.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_SEND = 2'd2,
    ST_RECV = 2'd3
  } xfer_state_t;

  localparam logic [1:0] REG_SIZE  = 2'd0;
  localparam logic [1:0] REG_FIRST = 2'd1;
  localparam logic [1:0] REG_MODE  = 2'd2;
  localparam logic [1:0] REG_STAT  = 2'd3;

  localparam logic [3:0] STAT_FILL = 4'hF;
endpackage

// File: rtl/cfgport_stage_ram.sv
module cfgport_stage_ram #(
  parameter int DEPTH = 512,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_waddr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          eng_we,
  input  logic [AW-1:0] eng_waddr,
  input  logic [DW-1:0] eng_wdata,
  input  logic [AW-1:0] bus_raddr,
  output logic [DW-1:0] bus_q,
  input  logic [AW-1:0] eng_raddr,
  output logic [DW-1:0] eng_q
);
  logic [DW-1:0] mem [DEPTH];

  // engine write wins over a colliding bus write
  always_ff @(posedge clk) begin
    if (eng_we)
      mem[eng_waddr] <= eng_wdata;
    else if (bus_we)
      mem[bus_waddr] <= bus_wdata;
    bus_q <= mem[bus_raddr];
    eng_q <= mem[eng_raddr];
  end
endmodule

// File: rtl/cfgport_engine.sv
module cfgport_engine
  import cfgport_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_rb,
  input  logic          abort,
  input  logic [CW-1:0] beats,
  input  logic [AW-1:0] first,
  output logic          done,
  output logic          cfg_valid,
  input  logic          cfg_ready,
  input  logic          rb_valid,
  output logic          rb_ready,
  output logic [AW-1:0] ram_raddr,
  output logic          ram_we,
  output logic [AW-1:0] ram_waddr
);
  xfer_state_t   state;
  logic [AW-1:0] ptr;
  logic [CW-1:0] left;
  logic          accept, take, beat, last, launch;

  assign accept = (state == ST_SEND) && cfg_ready;
  assign take   = (state == ST_RECV) && rb_valid;
  assign beat   = accept || take;
  assign last   = beat && (left == CW'(1));
  assign launch = start && (state == ST_IDLE) && !abort;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b1;
      ptr   <= '0;
      left  <= '0;
    end else if (abort) begin
      state <= ST_IDLE;
      done  <= 1'b1;
    end else if (launch) begin
      ptr  <= first;
      left <= beats;
      if (beats != '0) begin
        done  <= 1'b0;
        state <= start_rb ? ST_RECV : ST_LOAD;
      end
    end else begin
      case (state)
        ST_LOAD: state <= ST_SEND;
        ST_SEND, ST_RECV: begin
          if (beat) begin
            ptr  <= ptr + AW'(1);
            left <= left - CW'(1);
            if (last) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // look one word ahead on acceptance so a word can leave every cycle
  assign ram_raddr = accept ? ptr + AW'(1) : ptr;
  assign ram_we    = take;
  assign ram_waddr = ptr;
  assign cfg_valid = (state == ST_SEND);
  assign rb_ready  = (state == ST_RECV);

  AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    launch && (beats != '0) |=> !done); // R4
  AST_ZERO_SIZE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    launch && (beats == '0) |=> done && !cfg_valid && !rb_ready); // R8
  AST_DONE_PORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cfg_valid && !rb_ready); // R7
  AST_LAST_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    last && !abort |=> done); // R7
  AST_ABORT_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> done && !cfg_valid && !rb_ready); // R10
  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    beat |=> ptr == $past(ptr) + AW'(1)); // R9
  AST_BUSY_MODE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rb_ready && !beat && !abort |=> rb_ready); // R12
endmodule

// File: rtl/cfgport_xfer.sv
module cfgport_xfer
  import cfgport_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int ABW  = AW + 3,
  localparam int SZW  = AW + 3,
  localparam int CW   = AW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [ABW-1:0] bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic           cfg_valid,
  input  logic           cfg_ready,
  output logic [DW-1:0]  cfg_data,
  input  logic           rb_valid,
  output logic           rb_ready,
  input  logic [DW-1:0]  rb_data,
  input  logic           port_abort_n,
  input  logic           port_rd_busy,
  input  logic           port_aligned,
  input  logic           port_cfg_err
);
  logic           reg_sel;
  logic [1:0]     reg_idx;
  logic [AW-1:0]  word_idx;
  logic [SZW-1:0] size_q;
  logic [AW-1:0]  first_q;
  logic           done;
  logic           start_pulse, abort_pulse, buf_we;
  logic           rd_reg_q;
  logic [DW-1:0]  reg_rdata_q, reg_rdata_d, ram_bus_q, status_word;
  logic           eng_we;
  logic [AW-1:0]  eng_raddr, eng_waddr;
  logic           unused_bits;

  assign reg_sel  = bus_addr[ABW-1];
  assign reg_idx  = bus_addr[3:2];
  assign word_idx = bus_addr[AW+1:2];

  assign start_pulse = bus_wr && reg_sel && (reg_idx == REG_MODE);
  assign abort_pulse = bus_wr && reg_sel && (reg_idx == REG_STAT);
  assign buf_we      = bus_wr && !reg_sel;

  assign status_word = {{(DW-9){1'b0}}, port_cfg_err, port_aligned,
                        port_rd_busy, port_abort_n, STAT_FILL, done};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      size_q  <= '0;
      first_q <= '0;
    end else if (bus_wr && reg_sel) begin
      if (reg_idx == REG_SIZE)  size_q  <= bus_wdata[SZW-1:0];
      if (reg_idx == REG_FIRST) first_q <= bus_wdata[AW-1:0];
    end
  end

  always_comb begin
    case (reg_idx)
      REG_SIZE:  reg_rdata_d = DW'(size_q);
      REG_FIRST: reg_rdata_d = DW'(first_q);
      REG_STAT:  reg_rdata_d = status_word;
      default:   reg_rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_reg_q    <= 1'b0;
      reg_rdata_q <= '0;
    end else if (bus_rd) begin
      rd_reg_q    <= reg_sel;
      reg_rdata_q <= reg_rdata_d;
    end
  end

  assign bus_rdata = rd_reg_q ? reg_rdata_q : ram_bus_q;

  cfgport_stage_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
    .clk       (clk),
    .bus_we    (buf_we),
    .bus_waddr (word_idx),
    .bus_wdata (bus_wdata),
    .eng_we    (eng_we),
    .eng_waddr (eng_waddr),
    .eng_wdata (rb_data),
    .bus_raddr (word_idx),
    .bus_q     (ram_bus_q),
    .eng_raddr (eng_raddr),
    .eng_q     (cfg_data)
  );

  cfgport_engine #(.DEPTH(DEPTH)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_pulse),
    .start_rb  (bus_wdata[0]),
    .abort     (abort_pulse),
    .beats     (size_q[SZW-1:2]),
    .first     (first_q),
    .done      (done),
    .cfg_valid (cfg_valid),
    .cfg_ready (cfg_ready),
    .rb_valid  (rb_valid),
    .rb_ready  (rb_ready),
    .ram_raddr (eng_raddr),
    .ram_we    (eng_we),
    .ram_waddr (eng_waddr)
  );

  assign unused_bits = ^{bus_addr[1:0], bus_wdata[DW-1:SZW]};

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && !cfg_ready && !abort_pulse && !buf_we && !$past(buf_we)
    |=> $stable(cfg_data)); // R5
  AST_STATUS_WRITE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |=> !cfg_valid && !rb_ready); // R10
endmodule

// File: tb/cfgport_xfer_test.sv
`timescale 1ns/1ps
module cfgport_xfer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cfg_valid, cfg_ready = 1'b0;
  logic [31:0] cfg_data;
  logic        rb_valid = 1'b0, rb_ready;
  logic [31:0] rb_data = '0;
  logic        port_abort_n = 1'b0, port_rd_busy = 1'b0;
  logic        port_aligned = 1'b0, port_cfg_err = 1'b0;

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit finished = 0;
  logic [31:0] sink [0:63];
  int sink_n = 0, src_n = 0;
  bit stall_on = 0, ready_hold = 0, rb_en = 0;

  always #2 clk = ~clk;

  cfgport_xfer uut (.*);

  function automatic logic [31:0] fill_pat(int i);
    return 32'hC0DE0000 ^ (i * 32'h01010101);
  endfunction
  function automatic logic [31:0] src_pat(int i);
    return 32'hBEEF0000 + i;
  endfunction

  // port stub: synchronous, one registered decision per edge
  always @(posedge clk) begin
    automatic int nidx = src_n;
    cyc <= cyc + 1;
    if (cfg_valid && cfg_ready) begin
      sink[sink_n % 64] <= cfg_data;
      sink_n <= sink_n + 1;
    end
    cfg_ready <= ready_hold ? 1'b0 : (stall_on ? ((cyc % 3) != 2) : 1'b1);
    if (rb_valid && rb_ready) nidx = src_n + 1;
    src_n    <= nidx;
    rb_data  <= src_pat(nidx);
    rb_valid <= rb_en && ((cyc % 4) != 1);
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_done(string tag);
    logic [31:0] s;
    for (int k = 0; k < 3000; k++) begin
      bus_read(12'h80C, s);
      if (s[0]) return;
    end
    check(tag, 32'd0, 32'd1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    bus_read(12'h80C, v); check("R1 status after reset", v, 32'h0000001F);
    bus_read(12'h800, v); check("R1 size after reset", v, 32'd0);
    bus_read(12'h804, v); check("R1 first index after reset", v, 32'd0);
    check("R1 port strobes idle", {30'd0, cfg_valid, rb_ready}, 32'd0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    bus_write(12'h800, 32'h0000_0ABC);
    bus_write(12'h804, 32'h0000_0155);
    bus_read(12'h800, v); check("R3 size readback", v, 32'h0000_0ABC);
    bus_read(12'h804, v); check("R3 first index readback", v, 32'h0000_0155);
    bus_read(12'h808, v); check("R3 mode reads zero", v, 32'd0);
  endtask

  task automatic t_buffer();
    logic [31:0] v;
    bus_write(12'h000, 32'h11223344);
    bus_write(12'h7FC, 32'hA5A5_0001);
    bus_write(12'h190, 32'hDEAD_BEEF);
    bus_read(12'h000, v); check("R2 word 0", v, 32'h11223344);
    bus_read(12'h7FC, v); check("R2 word 511", v, 32'hA5A5_0001);
    bus_read(12'h190, v); check("R2 word 100", v, 32'hDEAD_BEEF);
  endtask

  task automatic t_flags();
    logic [31:0] v;
    port_abort_n = 1'b1; port_aligned = 1'b1;
    bus_read(12'h80C, v); check("R11 status abort_n+aligned", v, 32'h000000BF);
    port_abort_n = 1'b0; port_aligned = 1'b0;
    port_rd_busy = 1'b1; port_cfg_err = 1'b1;
    bus_read(12'h80C, v); check("R11 status busy+err", v, 32'h0000015F);
    port_rd_busy = 1'b0; port_cfg_err = 1'b0;
  endtask

  task automatic run_config(string tag, int first, int bytes, bit stall);
    logic [31:0] v;
    int words = bytes / 4;
    for (int i = 0; i < words; i++)
      bus_write(12'((((first + i) % 512) * 4)), fill_pat(i + first));
    stall_on = stall;
    sink_n = 0;
    bus_write(12'h800, 32'(bytes));
    bus_write(12'h804, 32'(first));
    bus_write(12'h808, 32'd0);
    bus_read(12'h80C, v); check({tag, " R4 done low while running"}, {31'd0, v[0]}, 32'd0);
    wait_done(tag);
    check({tag, " R7 cfg_valid low after done"}, {31'd0, cfg_valid}, 32'd0);
    check({tag, " word count"}, 32'(sink_n), 32'(words));
    for (int i = 0; i < words; i++)
      check({tag, " word"}, sink[i], fill_pat(i + first));
    stall_on = 0;
  endtask

  task automatic t_readback();
    logic [31:0] v;
    bus_write(12'h19C, 32'h5555AAAA);
    src_n = 0; rb_en = 1;
    bus_write(12'h800, 32'd12);
    bus_write(12'h804, 32'd100);
    bus_write(12'h808, 32'd1);
    wait_done("R6 readback");
    rb_en = 0;
    for (int i = 0; i < 3; i++) begin
      bus_read(12'((100 + i) * 4), v);
      check("R6 stored word", v, src_pat(i));
    end
    bus_read(12'h19C, v); check("R6 word past run untouched", v, 32'h5555AAAA);
    check("R6 handshake count", 32'(src_n), 32'd3);
    check("R7 rb_ready low after done", {31'd0, rb_ready}, 32'd0);
  endtask

  task automatic t_zero();
    logic [31:0] v;
    sink_n = 0;
    bus_write(12'h800, 32'd3);
    bus_write(12'h808, 32'd0);
    check("R8 no cfg_valid", {31'd0, cfg_valid}, 32'd0);
    bus_read(12'h80C, v); check("R8 done stays 1", {31'd0, v[0]}, 32'd1);
    repeat (4) @(negedge clk);
    check("R8 no word sent", 32'(sink_n), 32'd0);
  endtask

  task automatic t_abort();
    logic [31:0] v;
    rb_en = 0;
    bus_write(12'h800, 32'd8);
    bus_write(12'h808, 32'd1);
    check("R10 readback waiting", {31'd0, rb_ready}, 32'd1);
    bus_write(12'h80C, 32'h0000FEFE);
    check("R10 rb_ready dropped", {31'd0, rb_ready}, 32'd0);
    bus_read(12'h80C, v); check("R10 done after abort", {31'd0, v[0]}, 32'd1);
  endtask

  task automatic t_busy_start();
    logic [31:0] v;
    bus_write(12'h000, fill_pat(0));
    bus_write(12'h004, fill_pat(1));
    ready_hold = 1; sink_n = 0;
    bus_write(12'h800, 32'd8);
    bus_write(12'h804, 32'd0);
    bus_write(12'h808, 32'd0);
    bus_write(12'h808, 32'd1);
    check("R12 mode kept (no rb_ready)", {31'd0, rb_ready}, 32'd0);
    check("R12 still sending", {31'd0, cfg_valid}, 32'd1);
    bus_read(12'h80C, v); check("R12 still busy", {31'd0, v[0]}, 32'd0);
    ready_hold = 0;
    wait_done("R12 finish");
    check("R12 word count", 32'(sink_n), 32'd2);
    check("R12 word 0", sink[0], fill_pat(0));
    check("R12 word 1", sink[1], fill_pat(1));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_buffer();
    t_flags();
    run_config("R5 configure stalled", 8, 16, 1'b1);
    run_config("R5 configure odd size", 20, 10, 1'b0);
    run_config("R9 configure wrap", 510, 16, 1'b1);
    t_readback();
    t_zero();
    t_abort();
    t_busy_start();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule